// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Pair

This block keeps the pending-interrupt flags and the per-source enable mask of a general-purpose interface peripheral, and turns them into one level-sensitive interrupt line. Three event sources feed it with one-cycle set strobes: a shift-register transfer that has completed, the second timer, and the first timer. Software sees the pair as two 8-bit registers on a byte register bus with a 4-bit register select. The flag register sits at select 13 and the mask register at select 14.

Flags are set by the strobes. They are cleared in two ways: by writing ones to the flag register, or as a side effect of reading the data register of the source that raised them. The mask register is written in set-or-clear form, with bit 7 of the written byte choosing the operation. Bit 7 of each read-back value is not stored. It is made from the live register state. The interrupt output is registered. Only the shift-transfer and first-timer sources can drive it.

Top module: `vif_irq_ctrl`

## Requirements
- R1: A write to select 13 clears each flag bit whose written data bit is 1. Flag bits whose written data bit is 0 keep their value.
- R2: A write to select 14 with data bit 7 = 1 sets the mask bits that are 1 in data bits 6:0. The other mask bits keep their value.
- R3: A write to select 14 with data bit 7 = 0 clears the mask bits that are 1 in data bits 6:0. The other mask bits keep their value.
- R4: While the select is 14, `rd_data` is {1, mask[6:0]}. Bit 7 is always 1.
- R5: While the select is 13, `rd_data` is {p, flag[6:0]}, where p is 1 when any flag bit, including the timer-2 flag, is set with its mask bit also set. For every select other than 13 and 14, `rd_data` is 0.
- R6: `irq` is 1 in the cycle after an edge exactly when, before that edge, flag/mask bit 2 (shift transfer) or bit 6 (timer 1) were both set. Flag bit 5 (timer 2) never drives `irq`.
- R7: A read strobe has these side effects: at select 10 it clears flag bit 2, at select 4 it clears flag bit 6, and at select 8 it clears flag bit 5. Writes to these selects clear no flag.
- R8: Strobes set flags as follows: `sr_done` sets flag bit 2, `t2_done` sets bit 5 and `t1_done` sets bit 6. When a set strobe and a clear (write or read side effect) hit the same bit in the same cycle, the bit ends up set.
- R9: After reset both registers are 0 and `irq` is 0, so select 13 reads 0x00 and select 14 reads 0x80.
- R10: Flag bits 0, 1, 3 and 4 have no source and always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (for read side effects) |
| reg_sel | input | 4 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read-back value for the current select |
| sr_done | input | 1 | Shift transfer complete set strobe |
| t2_done | input | 1 | Timer 2 set strobe |
| t1_done | input | 1 | Timer 1 set strobe |
| irq | output | 1 | Registered interrupt level |

## Verification
A set strobe from a source can fall in the same cycle as a clear of the same flag. The clear can come either from a ones-write to select 13 or from a read of the source's data register. Directed cases put `sr_done` together with a read at select 10, `t1_done` together with a flag write of 0x7F, and `t2_done` together with a read at select 8. The random phase then fires strobes, writes and reads together at high rates. A reference model in the bench applies the clears first and the sets after them. Each cycle, the flag read-back is compared with this model, which expects the bit to stay set.

// File: rtl/vif_irq_pkg.sv
package vif_irq_pkg;

   // Identifies one of the three event sources
   typedef enum logic [1:0] {
      SRC_SHIFT = 2'd0,
      SRC_TMR2  = 2'd1,
      SRC_TMR1  = 2'd2
   } irq_src_e;

   // One-cycle event strobes, grouped
   typedef struct packed {
      logic tmr1;
      logic tmr2;
      logic shift;
   } src_strobe_t;

endpackage

// File: rtl/vif_flag_bank.sv
module vif_flag_bank #(
   parameter int FLD_W = 7,
   parameter logic [FLD_W-1:0] SRC_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLD_W-1:0] set_vec,
   input  logic [FLD_W-1:0] clr_vec,
   output logic [FLD_W-1:0] flag_q
);

   for (genvar i = 0; i < FLD_W; i++) begin : g_bit
      if (SRC_MASK[i]) begin : g_src
         // Bit with a source: clear first, then set, so the set wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
               flag_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
               flag_q[i] <= 1'b0;
            end
         end
      end else begin : g_none
         // Bit without a source: it can never be set
         assign flag_q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/vif_mask_bank.sv
module vif_mask_bank #(
   parameter int FLD_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [FLD_W:0]   wr_data,
   output logic [FLD_W-1:0] mask_q
);

   logic             op_set;
   logic [FLD_W-1:0] sel_bits;
   logic [FLD_W-1:0] mask_d;

   assign op_set   = wr_data[FLD_W];
   assign sel_bits = wr_data[FLD_W-1:0];

   always_comb begin
      mask_d = mask_q;
      if (wr_stb) begin
         if (op_set) begin
            mask_d = mask_q | sel_bits;
         end else begin
            mask_d = mask_q & ~sel_bits;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else begin
         mask_q <= mask_d;
      end
   end

endmodule

// File: rtl/vif_irq_out.sv
module vif_irq_out #(
   parameter int FLD_W = 7,
   parameter logic [FLD_W-1:0] LINE_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLD_W-1:0] flag_q,
   input  logic [FLD_W-1:0] mask_q,
   output logic             any_pend,
   output logic             irq_q
);

   logic [FLD_W-1:0] pend;

   assign pend     = flag_q & mask_q;
   assign any_pend = |pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= |(pend & LINE_MASK);
      end
   end

endmodule

// File: rtl/vif_irq_ctrl.sv
module vif_irq_ctrl #(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 4,
   parameter int FLAG_SEL  = 13,
   parameter int MASK_SEL  = 14,
   parameter int SHIFT_SEL = 10,
   parameter int T1LO_SEL  = 4,
   parameter int T2LO_SEL  = 8,
   parameter int SR_BIT    = 2,
   parameter int T2_BIT    = 5,
   parameter int T1_BIT    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sr_done,
   input  logic              t2_done,
   input  logic              t1_done,
   output logic              irq
);
   import vif_irq_pkg::*;

   localparam int FLD_W = DATA_W - 1;
   localparam logic [FLD_W-1:0] SR_HOT = FLD_W'(1) << SR_BIT;
   localparam logic [FLD_W-1:0] T2_HOT = FLD_W'(1) << T2_BIT;
   localparam logic [FLD_W-1:0] T1_HOT = FLD_W'(1) << T1_BIT;
   localparam logic [FLD_W-1:0] SRC_MASK  = SR_HOT | T2_HOT | T1_HOT;
   localparam logic [FLD_W-1:0] LINE_MASK = SR_HOT | T1_HOT;

   // Checks on the parameters, done at elaboration
   if (DATA_W < 8) begin : g_bad_w
      $error("DATA_W must be at least 8");
   end
   if (FLAG_SEL == MASK_SEL) begin : g_bad_sel
      $error("flag and mask selects must differ");
   end
   if (FLAG_SEL >= (1 << SEL_W) || MASK_SEL >= (1 << SEL_W)) begin : g_bad_rng
      $error("register select out of range");
   end
   if (SR_BIT >= FLD_W || T2_BIT >= FLD_W || T1_BIT >= FLD_W) begin : g_bad_bit
      $error("source bit position out of range");
   end
   if (SR_BIT == T1_BIT || SR_BIT == T2_BIT || T1_BIT == T2_BIT) begin : g_bad_dup
      $error("source bit positions must be distinct");
   end

   src_strobe_t      stb;
   logic [FLD_W-1:0] set_vec;
   logic [FLD_W-1:0] clr_wr;
   logic [FLD_W-1:0] clr_rd;
   logic [FLD_W-1:0] flag_q;
   logic [FLD_W-1:0] mask_q;
   logic             any_pend;
   logic             hit_flag;
   logic             hit_mask;

   assign stb.shift = sr_done;
   assign stb.tmr2  = t2_done;
   assign stb.tmr1  = t1_done;

   assign hit_flag = (reg_sel == SEL_W'(FLAG_SEL));
   assign hit_mask = (reg_sel == SEL_W'(MASK_SEL));

   assign set_vec = ({FLD_W{stb.shift}} & SR_HOT)
                  | ({FLD_W{stb.tmr2}}  & T2_HOT)
                  | ({FLD_W{stb.tmr1}}  & T1_HOT);

   assign clr_wr = (wr_en && hit_flag) ? wr_data[FLD_W-1:0] : '0;

   always_comb begin
      clr_rd = '0;
      if (rd_en) begin
         if (reg_sel == SEL_W'(SHIFT_SEL)) clr_rd = clr_rd | SR_HOT;
         if (reg_sel == SEL_W'(T1LO_SEL))  clr_rd = clr_rd | T1_HOT;
         if (reg_sel == SEL_W'(T2LO_SEL))  clr_rd = clr_rd | T2_HOT;
      end
   end

   vif_flag_bank #(
      .FLD_W    (FLD_W),
      .SRC_MASK (SRC_MASK)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_wr | clr_rd),
      .flag_q  (flag_q)
   );

   vif_mask_bank #(
      .FLD_W (FLD_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_en && hit_mask),
      .wr_data (wr_data[FLD_W:0]),
      .mask_q  (mask_q)
   );

   vif_irq_out #(
      .FLD_W     (FLD_W),
      .LINE_MASK (LINE_MASK)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_q   (flag_q),
      .mask_q   (mask_q),
      .any_pend (any_pend),
      .irq_q    (irq)
   );

   // Read-back: bit 7 is made here, never stored
   always_comb begin
      rd_data = '0;
      if (hit_flag) begin
         rd_data[FLD_W-1:0] = flag_q;
         rd_data[FLD_W]     = any_pend;
      end else if (hit_mask) begin
         rd_data[FLD_W-1:0] = mask_q;
         rd_data[FLD_W]     = 1'b1;
      end
   end

endmodule

// File: rtl/vif_irq_ctrl_chk.sv
module vif_irq_ctrl_chk #(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 4,
   parameter int FLAG_SEL  = 13,
   parameter int MASK_SEL  = 14,
   parameter int SHIFT_SEL = 10,
   parameter int T1LO_SEL  = 4,
   parameter int T2LO_SEL  = 8,
   parameter int SR_BIT    = 2,
   parameter int T2_BIT    = 5,
   parameter int T1_BIT    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [SEL_W-1:0]  reg_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              sr_done,
   input logic              t2_done,
   input logic              t1_done,
   input logic              irq,
   input logic [DATA_W-2:0] flag_q,
   input logic [DATA_W-2:0] mask_q
);
   localparam int FLD_W = DATA_W - 1;
   localparam logic [FLD_W-1:0] NOSRC =
      ~((FLD_W'(1) << SR_BIT) | (FLD_W'(1) << T2_BIT) | (FLD_W'(1) << T1_BIT));

   logic any_set;
   logic wflag;
   logic wmask;
   logic rside;

   assign any_set = sr_done | t2_done | t1_done;
   assign wflag   = wr_en && (reg_sel == SEL_W'(FLAG_SEL));
   assign wmask   = wr_en && (reg_sel == SEL_W'(MASK_SEL));
   assign rside   = rd_en && (reg_sel == SEL_W'(SHIFT_SEL) ||
                              reg_sel == SEL_W'(T1LO_SEL)  ||
                              reg_sel == SEL_W'(T2LO_SEL));

   // R1
   flag_wclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wflag && !any_set && !rside) |=>
         flag_q == ($past(flag_q) & ~$past(wr_data[FLD_W-1:0])));

   // R2
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wmask && wr_data[FLD_W]) |=>
         mask_q == ($past(mask_q) | $past(wr_data[FLD_W-1:0])));

   // R3
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wmask && !wr_data[FLD_W]) |=>
         (mask_q & $past(wr_data[FLD_W-1:0])) == '0);

   // R4
   mask_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_W'(MASK_SEL)) |-> (rd_data[FLD_W] && rd_data[FLD_W-1:0] == mask_q));

   // R6
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q[SR_BIT] && mask_q[SR_BIT]) || (flag_q[T1_BIT] && mask_q[T1_BIT])) |=> irq);

   // R6
   t2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(flag_q[SR_BIT] && mask_q[SR_BIT]) && !(flag_q[T1_BIT] && mask_q[T1_BIT])) |=> !irq);

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_done && t1_done) |=> (flag_q[SR_BIT] && flag_q[T1_BIT]));

   // R10
   nosrc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q & NOSRC) == '0);

endmodule

bind vif_irq_ctrl vif_irq_ctrl_chk #(
   .DATA_W    (DATA_W),
   .SEL_W     (SEL_W),
   .FLAG_SEL  (FLAG_SEL),
   .MASK_SEL  (MASK_SEL),
   .SHIFT_SEL (SHIFT_SEL),
   .T1LO_SEL  (T1LO_SEL),
   .T2LO_SEL  (T2LO_SEL),
   .SR_BIT    (SR_BIT),
   .T2_BIT    (T2_BIT),
   .T1_BIT    (T1_BIT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .reg_sel (reg_sel),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .sr_done (sr_done),
   .t2_done (t2_done),
   .t1_done (t1_done),
   .irq     (irq),
   .flag_q  (flag_q),
   .mask_q  (mask_q)
);

// File: tb/sim_vif_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vif_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] reg_sel = 4'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       sr_done = 1'b0;
   logic       t2_done = 1'b0;
   logic       t1_done = 1'b0;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [6:0] m_flag = '0;
   logic [6:0] m_mask = '0;
   logic       m_irq  = 1'b0;

   always #2.5 clk = ~clk;

   vif_irq_ctrl u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .reg_sel (reg_sel),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .sr_done (sr_done),
      .t2_done (t2_done),
      .t1_done (t1_done),
      .irq     (irq)
   );

   function automatic logic [6:0] f_next(logic [6:0] f, logic w, logic r,
                                         logic [3:0] s, logic [7:0] d,
                                         logic sr, logic t2, logic t1);
      logic [6:0] clr = '0;
      logic [6:0] set = '0;
      if (w && s == 4'd13) clr = d[6:0];
      if (r && s == 4'd10) clr[2] = 1'b1;
      if (r && s == 4'd4)  clr[6] = 1'b1;
      if (r && s == 4'd8)  clr[5] = 1'b1;
      set[2] = sr; set[5] = t2; set[6] = t1;
      return (f & ~clr) | set;
   endfunction

   function automatic logic [6:0] m_next(logic [6:0] m, logic w,
                                         logic [3:0] s, logic [7:0] d);
      if (!(w && s == 4'd14)) return m;
      return d[7] ? (m | d[6:0]) : (m & ~d[6:0]);
   endfunction

   function automatic logic [7:0] exp_rd(logic [6:0] f, logic [6:0] m, logic [3:0] s);
      if (s == 4'd13) return {|(f & m), f};
      if (s == 4'd14) return {1'b1, m};
      return 8'h00;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // One bus cycle: drive, compare current outputs, advance the model
   task automatic cyc(logic w, logic r, logic [3:0] s, logic [7:0] d,
                      logic sr, logic t2, logic t1, string tag);
      string t;
      @(negedge clk);
      wr_en = w; rd_en = r; reg_sel = s; wr_data = d;
      sr_done = sr; t2_done = t2; t1_done = t1;
      #1;
      if (tag != "") t = tag;
      else if (s == 4'd14) t = "R4";
      else t = "R5";
      chk(t, rd_data, exp_rd(m_flag, m_mask, s));
      chk("R6 irq", {7'd0, irq}, {7'd0, m_irq});
      m_irq  = (m_flag[2] & m_mask[2]) | (m_flag[6] & m_mask[6]);
      m_flag = f_next(m_flag, w, r, s, d, sr, t2, t1);
      m_mask = m_next(m_mask, w, s, d);
      @(posedge clk);
   endtask

   task automatic idle(logic [3:0] s, string tag);
      cyc(1'b0, 1'b0, s, 8'h00, 1'b0, 1'b0, 1'b0, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      idle(4'd13, "R9 flags after reset");
      idle(4'd14, "R9 mask after reset");

      // R2: set mask bits 2 and 6
      cyc(1, 0, 4'd14, 8'hC4, 0, 0, 0, "");
      idle(4'd14, "R2 mask set");
      // R8 with R6: shift strobe, irq follows one cycle after the flag
      cyc(0, 0, 4'd13, 8'h00, 1, 0, 0, "");
      idle(4'd13, "R8 shift flag set");
      idle(4'd13, "R6 irq up");
      // R1: write 0 bits leaves flags, write 1 clears
      cyc(1, 0, 4'd13, 8'h3B, 0, 0, 0, "");
      idle(4'd13, "R1 zero bits kept");
      cyc(1, 0, 4'd13, 8'h04, 0, 0, 0, "");
      idle(4'd13, "R1 flag cleared");
      // R6: timer2 alone never drives irq
      cyc(1, 0, 4'd14, 8'hA0, 0, 0, 0, "");
      cyc(0, 0, 4'd13, 8'h00, 0, 1, 0, "");
      idle(4'd13, "R5 timer2 pending bit7");
      idle(4'd13, "R6 timer2 no irq");
      // R7: read side-effect clears
      cyc(0, 1, 4'd8, 8'h00, 0, 0, 0, "R7 read t2 low");
      idle(4'd13, "R7 timer2 cleared");
      cyc(0, 0, 4'd0, 8'h00, 1, 0, 1, "");
      cyc(1, 0, 4'd10, 8'hFF, 0, 0, 0, "R7 write no clear");
      idle(4'd13, "R7 write kept flags");
      cyc(0, 1, 4'd10, 8'h00, 0, 0, 0, "R7 read shift");
      idle(4'd13, "R7 shift cleared");
      cyc(0, 1, 4'd4, 8'h00, 0, 0, 0, "R7 read t1 low");
      idle(4'd13, "R7 timer1 cleared");
      // R8: set against clear in the same cycle
      cyc(0, 1, 4'd10, 8'h00, 1, 0, 0, "");
      idle(4'd13, "R8 set beats read clear");
      cyc(1, 0, 4'd13, 8'h7F, 0, 0, 1, "");
      idle(4'd13, "R8 set beats write clear");
      cyc(0, 1, 4'd8, 8'h00, 0, 1, 0, "");
      idle(4'd13, "R8 t2 set beats read clear");
      // R3: clear mask bits
      cyc(1, 0, 4'd14, 8'h44, 0, 0, 0, "");
      idle(4'd14, "R3 mask cleared");
      idle(4'd0, "R5 other select zero");
      // R10: sourceless bits stay 0 after a full flag write
      cyc(1, 0, 4'd13, 8'h00, 0, 0, 0, "");
      idle(4'd13, "R10 no stray flags");

      // Random phase
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] s;
         int k = $urandom % 6;
         case (k)
            0: s = 4'd13;
            1: s = 4'd14;
            2: s = 4'd10;
            3: s = 4'd4;
            4: s = 4'd8;
            default: s = 4'($urandom);
         endcase
         cyc(($urandom % 3) == 0, ($urandom % 2) == 0, s, 8'($urandom),
             ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0, "");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule